// File: doc/BRIEF.md
# Hill-Climbing Evolution Strategy Controller

This block runs a (1+1) evolution strategy over a configuration image. The image has `NCELL` cells, and each cell has `NMUX` multiplexer select fields. After reset the block clears the target device and downloads the whole image into it. It then asks an external evaluator to measure the parent over the long test set. After that it enters the search loop.

In each pass of the loop the block makes one offspring. A 16-bit LFSR drives three random reselections, and each reselection is logged in an undo log. The block then asks for a short fitness measurement. If the offspring scores at least as well as the parent, it becomes the new parent. Otherwise the three writes are undone in reverse order. After fifteen rejections in a row, the block clears the device and streams the parent image back into it.

Every change to the configuration leaves the block as a write on the `cfg_*` port. A device model or a real programming path can follow the image from these writes alone. The loop stops, between offspring, when the stop input is high.

Top module: `es_hill_ctrl`

## Requirements
- R1: After reset is released, `dev_clr_o` is high for one cycle. Then the block issues `NCELL*NMUX` writes in cell-major order (mux index fastest), all with select 0. It then raises a request with `ev_req_tests_o` = 50.
- R2: Each mutation is one write with cell < `NCELL`, mux < `NMUX` and select < `NIN`. The written select differs from the value that entry held before the write.
- R3: Each offspring consists of exactly three mutation writes, followed by a request with `ev_req_tests_o` = 24.
- R4: An offspring whose fitness is greater than or equal to the stored parent fitness is kept. No write follows its result before the next offspring's mutations begin.
- R5: A rejected offspring is followed by exactly three writes. Each one restores the old value of one of the three mutations, newest first.
- R6: On the fifteenth consecutive rejection, the three restoring writes are followed by a one-cycle `dev_clr_o` pulse. Then comes a full download of the parent image.
- R7: The consecutive-rejection count restarts from zero after every kept offspring and after every full reload.
- R8: When `stop_i` is high as the block finishes handling a result, `halted_o` rises. No request or write follows until reset.
- R9: A raised request keeps `ev_req_valid_o` high and `ev_req_tests_o` unchanged until `ev_req_ready_i` is seen high.
- R10: While `rst_n` is low, `dev_clr_o` is high and `cfg_we_o`, `ev_req_valid_o` and `halted_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_i | input | 1 | Request to end the search after the current decision |
| cfg_we_o | output | 1 | Configuration write strobe |
| cfg_cell_o | output | $clog2(NCELL) | Cell index of the write |
| cfg_mux_o | output | $clog2(NMUX) | Multiplexer index within the cell |
| cfg_sel_o | output | $clog2(NIN) | Select value written |
| dev_clr_o | output | 1 | Clear the whole device configuration |
| ev_req_valid_o | output | 1 | Fitness measurement request |
| ev_req_ready_i | input | 1 | Evaluator accepts the request |
| ev_req_tests_o | output | $clog2(max(PARENT_TESTS,CHILD_TESTS)+1) | Number of tone tests to run |
| ev_res_valid_i | input | 1 | Fitness result strobe |
| ev_res_fit_i | input | FITW | Unsigned fixed-point fitness |
| halted_o | output | 1 | Search has stopped |

## Verification
The checker takes two things for granted. First, the evaluator returns exactly one result per accepted request. Second, it never raises `ev_res_valid_i` unless a request has been taken. The bench's evaluator model therefore answers each handshake once, a few cycles after it, and sometimes holds `ready` low for several cycles first.

The bench knows nothing of the LFSR sequence. It mirrors the device image from the write stream alone and clears its mirror on every clear pulse. It then judges mutations, restores and reloads against that mirror and against a snapshot of the last kept parent.

// File: rtl/es_hill_ctrl.sv
module es_hill_ctrl #(
  parameter int NCELL        = 100,
  parameter int NMUX         = 10,
  parameter int NIN          = 8,
  parameter int NMUT         = 3,
  parameter int FAIL_LIMIT   = 15,
  parameter int PARENT_TESTS = 50,
  parameter int CHILD_TESTS  = 24,
  parameter int FITW         = 16,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stop_i,
  output logic                    cfg_we_o,
  output logic [$clog2(NCELL)-1:0] cfg_cell_o,
  output logic [$clog2(NMUX)-1:0]  cfg_mux_o,
  output logic [$clog2(NIN)-1:0]   cfg_sel_o,
  output logic                    dev_clr_o,
  output logic                    ev_req_valid_o,
  input  logic                    ev_req_ready_i,
  output logic [$clog2((PARENT_TESTS > CHILD_TESTS ? PARENT_TESTS : CHILD_TESTS) + 1)-1:0] ev_req_tests_o,
  input  logic                    ev_res_valid_i,
  input  logic [FITW-1:0]         ev_res_fit_i,
  output logic                    halted_o
);
  localparam int CW  = $clog2(NCELL);
  localparam int MW  = $clog2(NMUX);
  localparam int SW  = $clog2(NIN);
  localparam int KW  = $clog2(NMUT + 1);
  localparam int FCW = $clog2(FAIL_LIMIT + 1);
  localparam int TW  = $clog2((PARENT_TESTS > CHILD_TESTS ? PARENT_TESTS : CHILD_TESTS) + 1);
  localparam logic [CW-1:0]  CMAX  = CW'(NCELL - 1);
  localparam logic [MW-1:0]  MMAX  = MW'(NMUX - 1);
  localparam logic [SW-1:0]  SMAX  = SW'(NIN - 1);
  localparam logic [KW-1:0]  KLAST = KW'(NMUT - 1);
  localparam logic [FCW-1:0] FLAST = FCW'(FAIL_LIMIT - 1);
  localparam logic [TW-1:0]  TP    = TW'(PARENT_TESTS);
  localparam logic [TW-1:0]  TC    = TW'(CHILD_TESTS);
  localparam logic [15:0]    TAPS  = 16'hB400;

  typedef enum logic [3:0] {
    S_CLR, S_LOAD, S_PREQ, S_PWAIT, S_NEXT, S_CELL, S_MUX,
    S_SEL, S_CREQ, S_CWAIT, S_UNDO, S_HALT
  } st_t;

  st_t            st;
  logic [15:0]    lfsr;
  logic [SW-1:0]  img [NCELL][NMUX];
  logic [CW-1:0]  ld_c, m_cell;
  logic [MW-1:0]  ld_m, m_mux;
  logic [KW-1:0]  k;
  logic [CW-1:0]  log_c [NMUT];
  logic [MW-1:0]  log_m [NMUT];
  logic [SW-1:0]  log_v [NMUT];
  logic [FITW-1:0] parent_fit;
  logic [FCW-1:0] fails;
  logic           boot;

  logic [CW-1:0] cell_draw;
  logic [MW-1:0] mux_draw;
  logic [SW-1:0] sel_draw, old_sel, new_sel;
  logic [KW-1:0] u;
  logic          sel_ok;

  assign cell_draw = lfsr[CW-1:0];
  assign mux_draw  = lfsr[15 -: MW];
  assign sel_draw  = lfsr[8 +: SW];
  assign old_sel   = img[m_cell][m_mux];
  assign new_sel   = (sel_draw != old_sel) ? sel_draw :
                     (old_sel == SMAX) ? '0 : old_sel + 1'b1;
  assign sel_ok    = (st == S_SEL) && (sel_draw <= SMAX);
  assign u         = k - 1'b1;

  assign dev_clr_o      = (st == S_CLR);
  assign halted_o       = (st == S_HALT);
  assign ev_req_valid_o = (st == S_PREQ) || (st == S_CREQ);
  assign ev_req_tests_o = (st == S_PREQ) ? TP : TC;
  assign cfg_we_o       = (st == S_LOAD) || sel_ok || (st == S_UNDO);

  always_comb begin
    cfg_cell_o = m_cell;
    cfg_mux_o  = m_mux;
    cfg_sel_o  = new_sel;
    if (st == S_LOAD) begin
      cfg_cell_o = ld_c;
      cfg_mux_o  = ld_m;
      cfg_sel_o  = img[ld_c][ld_m];
    end else if (st == S_UNDO) begin
      cfg_cell_o = log_c[u];
      cfg_mux_o  = log_m[u];
      cfg_sel_o  = log_v[u];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_CLR;
      lfsr       <= SEED;
      ld_c       <= '0;
      ld_m       <= '0;
      m_cell     <= '0;
      m_mux      <= '0;
      k          <= '0;
      parent_fit <= '0;
      fails      <= '0;
      boot       <= 1'b1;
      for (int c = 0; c < NCELL; c++)
        for (int m = 0; m < NMUX; m++)
          img[c][m] <= '0;
      for (int i = 0; i < NMUT; i++) begin
        log_c[i] <= '0;
        log_m[i] <= '0;
        log_v[i] <= '0;
      end
    end else begin
      lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? TAPS : 16'h0000);
      case (st)
        S_CLR: begin
          ld_c <= '0;
          ld_m <= '0;
          st   <= S_LOAD;
        end
        S_LOAD: begin
          if (ld_m == MMAX) begin
            ld_m <= '0;
            if (ld_c == CMAX) begin
              st   <= boot ? S_PREQ : S_NEXT;
              boot <= 1'b0;
            end else begin
              ld_c <= ld_c + 1'b1;
            end
          end else begin
            ld_m <= ld_m + 1'b1;
          end
        end
        S_PREQ:  if (ev_req_ready_i) st <= S_PWAIT;
        S_PWAIT: if (ev_res_valid_i) begin
          parent_fit <= ev_res_fit_i;
          st         <= S_NEXT;
        end
        S_NEXT: begin
          k  <= '0;
          st <= stop_i ? S_HALT : S_CELL;
        end
        S_CELL: if (cell_draw <= CMAX) begin
          m_cell <= cell_draw;
          st     <= S_MUX;
        end
        S_MUX: if (mux_draw <= MMAX) begin
          m_mux <= mux_draw;
          st    <= S_SEL;
        end
        S_SEL: if (sel_ok) begin
          img[m_cell][m_mux] <= new_sel;
          log_c[k] <= m_cell;
          log_m[k] <= m_mux;
          log_v[k] <= old_sel;
          k        <= k + 1'b1;
          st       <= (k == KLAST) ? S_CREQ : S_CELL;
        end
        S_CREQ:  if (ev_req_ready_i) st <= S_CWAIT;
        S_CWAIT: if (ev_res_valid_i) begin
          if (ev_res_fit_i >= parent_fit) begin
            parent_fit <= ev_res_fit_i;
            fails      <= '0;
            st         <= S_NEXT;
          end else begin
            st <= S_UNDO;
          end
        end
        S_UNDO: begin
          img[log_c[u]][log_m[u]] <= log_v[u];
          k <= u;
          if (k == KW'(1)) begin
            if (fails == FLAST) begin
              fails <= '0;
              st    <= S_CLR;
            end else begin
              fails <= fails + 1'b1;
              st    <= S_NEXT;
            end
          end
        end
        S_HALT:  st <= S_HALT;
        default: st <= S_CLR;
      endcase
    end
  end
endmodule

// File: rtl/es_hill_chk.sv
module es_hill_chk #(
  parameter int NCELL        = 100,
  parameter int NMUX         = 10,
  parameter int NIN          = 8,
  parameter int PARENT_TESTS = 50,
  parameter int CHILD_TESTS  = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_we_o,
  input logic [$clog2(NCELL)-1:0] cfg_cell_o,
  input logic [$clog2(NMUX)-1:0]  cfg_mux_o,
  input logic [$clog2(NIN)-1:0]   cfg_sel_o,
  input logic                     dev_clr_o,
  input logic                     ev_req_valid_o,
  input logic                     ev_req_ready_i,
  input logic [$clog2((PARENT_TESTS > CHILD_TESTS ? PARENT_TESTS : CHILD_TESTS) + 1)-1:0] ev_req_tests_o,
  input logic                     halted_o
);
  localparam int CW = $clog2(NCELL);
  localparam int MW = $clog2(NMUX);
  localparam int SW = $clog2(NIN);
  localparam int TW = $clog2((PARENT_TESTS > CHILD_TESTS ? PARENT_TESTS : CHILD_TESTS) + 1);
  localparam logic [CW-1:0] CMAX = CW'(NCELL - 1);
  localparam logic [MW-1:0] MMAX = MW'(NMUX - 1);
  localparam logic [SW-1:0] SMAX = SW'(NIN - 1);
  localparam logic [TW-1:0] TP   = TW'(PARENT_TESTS);
  localparam logic [TW-1:0] TC   = TW'(CHILD_TESTS);

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_o |-> (cfg_cell_o <= CMAX && cfg_mux_o <= MMAX && cfg_sel_o <= SMAX)); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_req_valid_o && !ev_req_ready_i) |=> (ev_req_valid_o && $stable(ev_req_tests_o))); // R9
  AST_TEST_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req_valid_o |-> (ev_req_tests_o == TP || ev_req_tests_o == TC)); // R3
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> (!ev_req_valid_o && !cfg_we_o && !dev_clr_o)); // R8
  AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_clr_o |=> (!dev_clr_o && cfg_we_o)); // R6
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!cfg_we_o && !ev_req_valid_o && !halted_o)); // R10
endmodule

bind es_hill_ctrl es_hill_chk #(
  .NCELL(NCELL), .NMUX(NMUX), .NIN(NIN),
  .PARENT_TESTS(PARENT_TESTS), .CHILD_TESTS(CHILD_TESTS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we_o(cfg_we_o), .cfg_cell_o(cfg_cell_o),
  .cfg_mux_o(cfg_mux_o), .cfg_sel_o(cfg_sel_o), .dev_clr_o(dev_clr_o),
  .ev_req_valid_o(ev_req_valid_o), .ev_req_ready_i(ev_req_ready_i),
  .ev_req_tests_o(ev_req_tests_o), .halted_o(halted_o)
);

// File: tb/es_hill_ctrl_tb.sv
module es_hill_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCELL = 100;
  localparam int NMUX  = 10;
  localparam int NIN   = 8;
  localparam int NENT  = NCELL * NMUX;
  localparam int WMAX  = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_i = 1'b0;
  logic cfg_we_o, dev_clr_o, ev_req_valid_o, halted_o;
  logic [6:0] cfg_cell_o;
  logic [3:0] cfg_mux_o;
  logic [2:0] cfg_sel_o;
  logic [5:0] ev_req_tests_o;
  logic ev_req_ready_i = 1'b0;
  logic ev_res_valid_i = 1'b0;
  logic [15:0] ev_res_fit_i = '0;

  es_hill_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i),
    .cfg_we_o(cfg_we_o), .cfg_cell_o(cfg_cell_o), .cfg_mux_o(cfg_mux_o),
    .cfg_sel_o(cfg_sel_o), .dev_clr_o(dev_clr_o),
    .ev_req_valid_o(ev_req_valid_o), .ev_req_ready_i(ev_req_ready_i),
    .ev_req_tests_o(ev_req_tests_o), .ev_res_valid_i(ev_res_valid_i),
    .ev_res_fit_i(ev_res_fit_i), .halted_o(halted_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  int mirror [NCELL][NMUX];
  int snap   [NCELL][NMUX];
  int cand   [NCELL][NMUX];
  int w_c [WMAX];
  int w_m [WMAX];
  int w_old [WMAX];
  int w_new [WMAX];
  int wcount = 0;
  int clrcount = 0;
  int wprev = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (dev_clr_o) begin
        clrcount++;
        for (int c = 0; c < NCELL; c++)
          for (int m = 0; m < NMUX; m++) mirror[c][m] = 0;
      end
      if (cfg_we_o && wcount < WMAX) begin
        w_c[wcount] = int'(cfg_cell_o);
        w_m[wcount] = int'(cfg_mux_o);
        w_new[wcount] = int'(cfg_sel_o);
        w_old[wcount] = (cfg_cell_o < NCELL && cfg_mux_o < NMUX) ? mirror[cfg_cell_o][cfg_mux_o] : -1;
        if (cfg_cell_o < NCELL && cfg_mux_o < NMUX) mirror[cfg_cell_o][cfg_mux_o] = int'(cfg_sel_o);
        wcount++;
      end
    end
  end

  function automatic int mismatches();
    int n = 0;
    for (int c = 0; c < NCELL; c++)
      for (int m = 0; m < NMUX; m++)
        if (mirror[c][m] != snap[c][m]) n++;
    return n;
  endfunction

  task automatic wait_req();
    while (!ev_req_valid_o) @(negedge clk);
    #1;
  endtask

  task automatic serve(input int fit, input int hold);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(ev_req_valid_o === 1'b1, "R9 request dropped before ready", int'(ev_req_valid_o), 1);
    end
    ev_req_ready_i = 1'b1;
    @(negedge clk);
    ev_req_ready_i = 1'b0;
    repeat (2) @(negedge clk);
    ev_res_fit_i = 16'(fit);
    ev_res_valid_i = 1'b1;
    @(negedge clk);
    ev_res_valid_i = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(dev_clr_o === 1'b1 && cfg_we_o === 1'b0 && ev_req_valid_o === 1'b0 && halted_o === 1'b0,
        "R10 outputs during reset", {dev_clr_o, cfg_we_o, ev_req_valid_o, halted_o}, 4'b1000);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic test_boot();
    int bad = 0;
    wait_req();
    chk(clrcount == 1, "R1 clear pulses before download", clrcount, 1);
    chk(wcount == NENT, "R1 download length", wcount, NENT);
    for (int i = 0; i < NENT; i++)
      if (w_c[i] != i / NMUX || w_m[i] != i % NMUX || w_new[i] != 0) bad++;
    chk(bad == 0, "R1 download order and values", bad, 0);
    chk(ev_req_tests_o == 6'd50, "R1 parent test count", int'(ev_req_tests_o), 50);
    snap = mirror;
    wprev = wcount;
    serve(100, 2);
  endtask

  task automatic child(input int fit, input bit accept, input bit reload, input int hold);
    int wm, bad, c0;
    wait_req();
    chk(wcount - wprev == 3, "R3 mutation writes per offspring", wcount - wprev, 3);
    chk(ev_req_tests_o == 6'd24, "R3 offspring test count", int'(ev_req_tests_o), 24);
    bad = 0;
    for (int j = wprev; j < wcount; j++)
      if (w_c[j] >= NCELL || w_m[j] >= NMUX || w_new[j] >= NIN || w_new[j] == w_old[j]) bad++;
    chk(bad == 0, "R2 mutation changes select in range", bad, 0);
    cand = mirror;
    wm = wcount;
    c0 = clrcount;
    serve(fit, hold);
    if (accept) begin
      snap = cand;
      wprev = wm;
    end else begin
      wait (wcount >= wm + 3);
      #1;
      bad = 0;
      for (int j = 0; j < 3; j++)
        if (w_c[wm+j] != w_c[wm-1-j] || w_m[wm+j] != w_m[wm-1-j] || w_new[wm+j] != w_old[wm-1-j]) bad++;
      chk(bad == 0, "R5 reverse-order restore", bad, 0);
      chk(mismatches() == 0, "R5 image equals parent after restore", mismatches(), 0);
      if (reload) begin
        wait (wcount >= wm + 3 + NENT);
        #1;
        chk(clrcount == c0 + 1, "R6 clear pulse before reload", clrcount - c0, 1);
        chk(mismatches() == 0, "R6 reloaded image equals parent", mismatches(), 0);
      end
      wprev = wcount;
    end
  endtask

  task automatic test_accept();
    child(120, 1'b1, 1'b0, 0);
    child(120, 1'b1, 1'b0, 3);
    wait_req();
    chk(wcount - wprev == 3, "R4 no restore after kept offspring", wcount - wprev, 3);
  endtask

  task automatic test_reject_then_accept();
    for (int i = 0; i < 10; i++) child(119, 1'b0, 1'b0, i % 3);
    child(130, 1'b1, 1'b0, 1);
  endtask

  task automatic test_reload();
    int c0 = clrcount;
    for (int i = 0; i < 14; i++) child(5, 1'b0, 1'b0, 0);
    chk(clrcount == c0, "R7 no reload after 14 rejects following accept", clrcount - c0, 0);
    child(5, 1'b0, 1'b1, 0);
    c0 = clrcount;
    for (int i = 0; i < 14; i++) child(129, 1'b0, 1'b0, 1);
    chk(clrcount == c0, "R7 no reload after 14 rejects following reload", clrcount - c0, 0);
    child(129, 1'b0, 1'b1, 0);
  endtask

  task automatic test_stop();
    int w0;
    wait_req();
    stop_i = 1'b1;
    w0 = wcount;
    serve(130, 0);
    repeat (40) @(negedge clk);
    chk(halted_o === 1'b1, "R8 halted after stop", int'(halted_o), 1);
    chk(ev_req_valid_o === 1'b0, "R8 no request after stop", int'(ev_req_valid_o), 0);
    chk(wcount == w0, "R8 no writes after stop", wcount - w0, 0);
    stop_i = 1'b0;
    repeat (10) @(negedge clk);
    chk(halted_o === 1'b1 && wcount == w0, "R8 halt holds after stop drops", int'(halted_o), 1);
  endtask

  initial begin
    test_reset();
    test_boot();
    test_accept();
    test_reject_then_accept();
    test_reload();
    test_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule